// File: doc/BRIEF.md
# APB Requester Transfer Sequencer

This block turns single commands into APB transfers. A command carries an address, a write flag and write data, and it is handed over with a valid/ready handshake. For each accepted command the sequencer spends one setup cycle with the select line high and the enable line low. It then enters the access phase with both high and stays there until the completer raises its ready input. The access phase has no fixed length. The completer sets it by holding ready low to insert wait states. During a wait state every bus output stays frozen.

A transfer finishes only on the cycle where select, enable and ready are all high. That cycle also captures read data, and it is the only point at which the next command can follow without a gap. On the next cycle a one-cycle done pulse reports the finished transfer together with the captured read data. If a new command is waiting, the bus goes straight back to setup. Otherwise it drops to idle.

Top module: `apb_txn_sequencer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, psel, penable and done_pulse are low and req_ready is high.
- R2: A command accepted from idle (req_valid and req_ready high at a clock edge) appears on the next cycle as a setup cycle: psel=1, penable=0, with paddr, pwrite and pwdata equal to the command's fields.
- R3: A setup cycle lasts exactly one cycle and is always followed by an access cycle with psel=1 and penable=1, whatever the value of pready during setup.
- R4: While pready is low in an access cycle, the next cycle is again an access cycle, and paddr, pwrite and pwdata stay unchanged.
- R5: A transfer completes only on a cycle with psel, penable and pready all high. done_pulse is high for exactly the one cycle after each completion and is low at every other time.
- R6: When done_pulse is high after a read, done_rdata equals the prdata value present on the completion cycle. prdata on setup and wait cycles is ignored. After a write, done_rdata is zero (parameter WR_RDATA_ZERO=1). done_rdata changes only together with done_pulse.
- R7: req_ready is high only when the sequencer is idle or on a completion cycle. A request presented while the block is busy and not at completion leaves the bus outputs unchanged.
- R8: A command accepted on a completion cycle produces a setup cycle on the very next cycle, with no idle cycle in between.
- R9: If no request is valid on the completion cycle, the next cycle is idle with psel=0 and penable=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Command offered |
| req_ready | output | 1 | Command accepted this cycle when req_valid is high |
| req_addr | input | ADDR_W | Command address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Command write data |
| done_pulse | output | 1 | One-cycle pulse after each completed transfer |
| done_rdata | output | DATA_W | Read data captured at completion |
| psel | output | 1 | APB select |
| penable | output | 1 | APB enable, high throughout the access phase |
| paddr | output | ADDR_W | APB address |
| pwrite | output | 1 | APB direction |
| pwdata | output | DATA_W | APB write data |
| pready | input | 1 | Completer ready, high to finish the access |
| prdata | input | DATA_W | Completer read data |

## Verification
The bench feeds prdata with fresh random values on every cycle. A design that samples read data on a wait cycle instead of the completion cycle therefore returns the wrong word. The bench also drives pready high during setup and idle. A sequencer that treats ready outside the access phase as a completion would then skip the access phase or pulse done early. Wait counts vary from zero to four, so a design that lets the address or data drift, or leaves access after a fixed number of cycles, shows up as a mismatch against the reference model. Requests are kept pending across completion edges to force back-to-back transfers: a design that inserts an idle cycle, or that drops back to idle while a command is waiting, fails the select and enable comparison.

// File: rtl/apb_seq_pkg.sv
package apb_seq_pkg;
   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_ACCESS = 2'd2
   } phase_e;
endpackage

// File: rtl/apb_phase_ctrl.sv
module apb_phase_ctrl
   import apb_seq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic pready,
   output logic req_ready,
   output logic accept,
   output logic complete,
   output logic hold,
   output logic psel,
   output logic penable
);
   phase_e st_q, st_d;

   assign complete  = (st_q == PH_ACCESS) && pready;
   assign hold      = (st_q == PH_ACCESS) && !pready;
   assign req_ready = (st_q == PH_IDLE) || complete;
   assign accept    = req_valid && req_ready;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         PH_IDLE:   st_d = accept ? PH_SETUP : PH_IDLE;
         PH_SETUP:  st_d = PH_ACCESS;
         PH_ACCESS: begin
            if (complete) st_d = accept ? PH_SETUP : PH_IDLE;
            else          st_d = PH_ACCESS;
         end
         default:   st_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= PH_IDLE;
      else        st_q <= st_d;
   end

   assign psel    = (st_q != PH_IDLE);
   assign penable = (st_q == PH_ACCESS);

   // R2
   accept_to_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !psel) |=> (psel && !penable));
   // R3
   setup_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && !penable) |=> (psel && penable));
   // R4
   wait_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && penable && !pready) |=> (psel && penable));
   // R8
   b2b_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && penable && pready && req_valid) |=> (psel && !penable));
   // R9
   idle_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && penable && pready && !req_valid) |=> (!psel && !penable));
   // R7
   ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && !(penable && pready)) |-> !req_ready);
endmodule

// File: rtl/apb_cmd_hold.sv
module apb_cmd_hold #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              hold,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [ADDR_W-1:0] paddr,
   output logic              pwrite,
   output logic [DATA_W-1:0] pwdata
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         paddr  <= '0;
         pwrite <= 1'b0;
         pwdata <= '0;
      end else if (accept) begin
         paddr  <= req_addr;
         pwrite <= req_write;
         pwdata <= req_wdata;
      end
   end

   // R4
   bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> ($stable(paddr) && $stable(pwrite) && $stable(pwdata)));
endmodule

// File: rtl/apb_rsp_capture.sv
module apb_rsp_capture #(
   parameter int DATA_W        = 32,
   parameter bit WR_RDATA_ZERO = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              complete,
   input  logic              pwrite,
   input  logic [DATA_W-1:0] prdata,
   output logic              done_pulse,
   output logic [DATA_W-1:0] done_rdata
);
   logic [DATA_W-1:0] next_rdata;

   generate
      if (WR_RDATA_ZERO) begin : g_wr_zero
         assign next_rdata = pwrite ? '0 : prdata;
      end else begin : g_wr_keep
         assign next_rdata = pwrite ? done_rdata : prdata;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_pulse <= 1'b0;
         done_rdata <= '0;
      end else begin
         done_pulse <= complete;
         if (complete) done_rdata <= next_rdata;
      end
   end

   // R5
   done_after_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |-> $past(complete));
   // R5
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |=> !done_pulse);
   // R6
   rdata_moves_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(done_rdata) |-> done_pulse);
endmodule

// File: rtl/apb_txn_sequencer.sv
module apb_txn_sequencer #(
   parameter int ADDR_W        = 16,
   parameter int DATA_W        = 32,
   parameter bit WR_RDATA_ZERO = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              done_pulse,
   output logic [DATA_W-1:0] done_rdata,
   output logic              psel,
   output logic              penable,
   output logic [ADDR_W-1:0] paddr,
   output logic              pwrite,
   output logic [DATA_W-1:0] pwdata,
   input  logic              pready,
   input  logic [DATA_W-1:0] prdata
);
   localparam int DATA_BYTES = DATA_W / 8;

   generate
      if (ADDR_W < 1 || ADDR_W > 64) begin : g_bad_addr
         $error("apb_txn_sequencer: ADDR_W must be 1..64");
      end
      if (DATA_W < 8 || DATA_W > 64 || DATA_BYTES * 8 != DATA_W) begin : g_bad_data
         $error("apb_txn_sequencer: DATA_W must be a multiple of 8 up to 64");
      end
   endgenerate

   logic accept, complete, hold;

   apb_phase_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .pready    (pready),
      .req_ready (req_ready),
      .accept    (accept),
      .complete  (complete),
      .hold      (hold),
      .psel      (psel),
      .penable   (penable)
   );

   apb_cmd_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .hold      (hold),
      .req_addr  (req_addr),
      .req_write (req_write),
      .req_wdata (req_wdata),
      .paddr     (paddr),
      .pwrite    (pwrite),
      .pwdata    (pwdata)
   );

   apb_rsp_capture #(.DATA_W(DATA_W), .WR_RDATA_ZERO(WR_RDATA_ZERO)) u_rsp (
      .clk        (clk),
      .rst_n      (rst_n),
      .complete   (complete),
      .pwrite     (pwrite),
      .prdata     (prdata),
      .done_pulse (done_pulse),
      .done_rdata (done_rdata)
   );

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (!psel && !penable && !done_pulse));
   // R3
   enable_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      penable |-> psel);
endmodule

// File: tb/tb_apb_txn_sequencer.sv
module tb_apb_txn_sequencer;
   localparam int AW = 16;
   localparam int DW = 32;
   localparam int NCYC = 4000;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          req_valid, req_write, pready;
   logic [AW-1:0] req_addr;
   logic [DW-1:0] req_wdata, prdata;
   logic          req_ready, done_pulse, psel, penable, pwrite;
   logic [DW-1:0] done_rdata, pwdata;
   logic [AW-1:0] paddr;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   apb_txn_sequencer #(.ADDR_W(AW), .DATA_W(DW)) dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
      .done_pulse(done_pulse), .done_rdata(done_rdata),
      .psel(psel), .penable(penable), .paddr(paddr),
      .pwrite(pwrite), .pwdata(pwdata),
      .pready(pready), .prdata(prdata)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int pick_waits(input int n);
      case (n)
         0: return 0;
         1: return 3;
         2: return 0;
         3: return 2;
         default: return int'($urandom % 5);
      endcase
   endfunction

   // reference model state: 0 idle, 1 setup, 2 access
   int            m_st, m_prev;
   logic [AW-1:0] m_addr;
   logic          m_wr, m_done;
   logic [DW-1:0] m_wdata, m_rdata;

   initial begin
      int wc, ntx, n_b2b, n_wait;
      bit pend, acc;
      void'($urandom(32'h5EED_1234));
      rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
      req_wdata = '0; pready = 1'b1; prdata = '0;
      wc = 0; ntx = 0; n_b2b = 0; n_wait = 0; pend = 1'b0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 psel", psel, 0);
      chk("R1 penable", penable, 0);
      chk("R1 done_pulse", done_pulse, 0);
      chk("R1 req_ready", req_ready, 1);
      m_st = 0; m_prev = 0; m_addr = '0; m_wr = 0; m_wdata = '0; m_done = 0; m_rdata = '0;
      rst_n = 1'b1;
      for (int cyc = 0; cyc < NCYC; cyc++) begin
         // completer model driven from observed bus
         if (psel && !penable) begin
            wc = pick_waits(ntx);
            ntx++;
         end
         if (psel && penable) begin
            if (wc == 0) pready = 1'b1;
            else begin pready = 1'b0; wc--; n_wait++; end
         end else begin
            pready = $urandom % 2;  // noise outside access must be ignored
         end
         prdata = $urandom;
         // command source
         if (!pend) begin
            if (cyc < 80 || (cyc < 2000 ? ($urandom % 3 != 0) : ($urandom % 4 == 0))) begin
               pend = 1'b1;
               req_addr  = AW'($urandom);
               req_write = $urandom % 2;
               req_wdata = $urandom;
            end
         end
         req_valid = pend;
         #1;
         // R7 ready only when idle or completing
         chk("R7 req_ready", req_ready, (m_st == 0) || (m_st == 2 && pready));
         acc = req_valid && ((m_st == 0) || (m_st == 2 && pready));
         // model next state
         m_prev = m_st;
         m_done = 1'b0;
         case (m_st)
            0: if (acc) begin m_st = 1; m_addr = req_addr; m_wr = req_write; m_wdata = req_wdata; end
            1: m_st = 2;
            default: if (pready) begin
               m_done = 1'b1;
               m_rdata = m_wr ? '0 : prdata;
               if (acc) begin
                  m_st = 1; n_b2b++;
                  m_addr = req_addr; m_wr = req_write; m_wdata = req_wdata;
               end else m_st = 0;
            end
         endcase
         if (acc) pend = 1'b0;
         @(negedge clk);
         // registered outputs vs model
         if (m_st == 1 && m_prev == 2) begin
            chk("R8 psel", psel, 1);
            chk("R8 penable", penable, 0);
         end else if (m_st == 0 && m_prev == 2) begin
            chk("R9 psel", psel, 0);
            chk("R9 penable", penable, 0);
         end else begin
            chk("R3 psel", psel, m_st != 0);
            chk("R3 penable", penable, m_st == 2);
         end
         if (m_st != 0) begin
            chk(m_prev == 2 && m_st == 2 ? "R4 paddr" : "R2 paddr", paddr, m_addr);
            chk(m_prev == 2 && m_st == 2 ? "R4 pwrite" : "R2 pwrite", pwrite, m_wr);
            chk(m_prev == 2 && m_st == 2 ? "R4 pwdata" : "R2 pwdata", pwdata, m_wdata);
         end
         chk("R5 done_pulse", done_pulse, m_done);
         chk("R6 done_rdata", done_rdata, m_rdata);
      end
      // coverage sanity: corner cases must have occurred
      chk("R8 back-to-back seen", n_b2b > 5, 1);
      chk("R4 wait states seen", n_wait > 20, 1);
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog R5: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule